// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small processor core that retires exactly one instruction per clock. Its registers and ALU are 64 bits wide, and its instructions are fixed at 32 bits in three regular layouts: register, immediate and jump. The core holds two internal arrays, one for instructions and one for data. Because they are separate, an instruction fetch and a data access can happen in the same cycle without competing for one memory.

A preload port fills either array from outside, word by word. While the port is active the core is frozen: the PC holds and nothing is written. Debug outputs expose the current PC and the register write that will be committed at the next rising edge. A test environment can therefore follow execution instruction by instruction.

The supported operations are 64-bit load and store, add, subtract, and, or, signed set-on-less-than, branch on equal, branch on not-equal, and a PC-relative jump.

Top module: `cpu_core`

## Requirements
- R1: While reset is held and after it is released, the PC reads 0 and every register reads zero until it is written.
- R2: Every instruction other than a taken branch or a jump advances the PC by 4 in one clock, so the PC always stays a multiple of 4.
- R3: With opcode 0x00, the register format takes rs from [25:21], rt from [20:16] and rd from [15:11]. Func [5:0] 0x20 writes rs+rt to rd, 0x22 writes rs-rt, 0x24 writes rs AND rt, and 0x25 writes rs OR rt.
- R4: Func 0x2A with opcode 0x00 writes 1 to rd when rs is less than rt as signed 64-bit values, and 0 otherwise.
- R5: Opcode 0x23 (load) writes into rt the data word at byte address rs + sign-extended imm[15:0]. Opcode 0x2B (store) writes the rt value to that word. Data words are 8 bytes, so address bits [2:0] are ignored, and addresses wrap modulo the array size.
- R6: Opcode 0x04 branches when rs equals rt and opcode 0x05 branches when they differ. The target is PC+4 plus the sign-extended imm[15:0] shifted left by 2. A branch that is not taken goes to PC+4.
- R7: Opcode 0x02 (jump) sets the PC to PC+4 plus the sign-extended offset [25:0] shifted left by 2.
- R8: Register 0 always reads zero, and an instruction whose destination is register 0 produces no register write.
- R9: While the preload enable is high, the PC holds and no register or data write comes from the core. The preload writes pl_data to word pl_addr of the data array when pl_dmem is 1, or to the instruction array (low 32 bits) when it is 0.
- R10: An unknown opcode, or an unknown func under opcode 0x00, writes nothing and advances the PC by 4. Only opcodes 0x00 and 0x23 ever write a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pl_en_i | input | 1 | Preload write enable; freezes the core |
| pl_dmem_i | input | 1 | Preload target: 1 data array, 0 instruction array |
| pl_addr_i | input | 6 | Preload word index |
| pl_data_i | input | 64 | Preload data word |
| dbg_pc_o | output | 64 | Current PC |
| dbg_wr_en_o | output | 1 | A register write commits at the next edge |
| dbg_wr_idx_o | output | 5 | Destination register of that write |
| dbg_wr_data_o | output | 64 | Value being written |

## Verification
The bench builds the core with its default parameters: a 64-bit datapath and 64-word instruction and data arrays. With the 64-word data array, a load at offset -8 from register 0 wraps to the last data word. This makes the full sign extension of the immediate and the modulo addressing visible through a single register write. The 64-bit width keeps the signed compare in set-on-less-than and the carries of the negative operands at their full size. Backward and forward branches and jumps stay within a program of fifteen words.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    // Field widths fixed by the instruction formats
    localparam int unsigned ILEN   = 32;
    localparam int unsigned REG_AW = 5;

    // Local opcode encoding (instr[31:26])
    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_JMP   = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_BNE   = 6'h05;
    localparam logic [5:0] OP_LD    = 6'h23;
    localparam logic [5:0] OP_SD    = 6'h2B;

    // Function codes for register-format instructions (instr[5:0])
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    mem_read;
        logic    mem_write;
        logic    branch_eq;
        logic    branch_ne;
        logic    jump;
        logic    alu_src_imm;
        logic    dst_is_rd;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/cpu_decoder.sv
module cpu_decoder
    import cpu_pkg::*;
(
    input  logic [ILEN-1:0] instr_i,
    output ctrl_t           ctrl_o
);

    logic [5:0] opcode;
    logic [5:0] func;

    assign opcode = instr_i[31:26];
    assign func   = instr_i[5:0];

    always_comb begin
        ctrl_o        = '0;
        ctrl_o.alu_op = ALU_ADD;
        unique case (opcode)
            OP_RTYPE: begin
                ctrl_o.dst_is_rd = 1'b1;
                unique case (func)
                    FN_ADD: begin ctrl_o.reg_write = 1'b1; ctrl_o.alu_op = ALU_ADD; end
                    FN_SUB: begin ctrl_o.reg_write = 1'b1; ctrl_o.alu_op = ALU_SUB; end
                    FN_AND: begin ctrl_o.reg_write = 1'b1; ctrl_o.alu_op = ALU_AND; end
                    FN_OR:  begin ctrl_o.reg_write = 1'b1; ctrl_o.alu_op = ALU_OR;  end
                    FN_SLT: begin ctrl_o.reg_write = 1'b1; ctrl_o.alu_op = ALU_SLT; end
                    default: ctrl_o.reg_write = 1'b0;
                endcase
            end
            OP_LD: begin
                ctrl_o.reg_write   = 1'b1;
                ctrl_o.mem_read    = 1'b1;
                ctrl_o.alu_src_imm = 1'b1;
            end
            OP_SD: begin
                ctrl_o.mem_write   = 1'b1;
                ctrl_o.alu_src_imm = 1'b1;
            end
            OP_BEQ: begin
                ctrl_o.branch_eq = 1'b1;
                ctrl_o.alu_op    = ALU_SUB;
            end
            OP_BNE: begin
                ctrl_o.branch_ne = 1'b1;
                ctrl_o.alu_op    = ALU_SUB;
            end
            OP_JMP: ctrl_o.jump = 1'b1;
            default: ctrl_o.reg_write = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  alu_op_e         op_i,
    output logic [XLEN-1:0] y_o,
    output logic            zero_o
);

    always_comb begin
        unique case (op_i)
            ALU_AND: y_o = a_i & b_i;
            ALU_OR:  y_o = a_i | b_i;
            ALU_ADD: y_o = a_i + b_i;
            ALU_SUB: y_o = a_i - b_i;
            ALU_SLT: y_o = ($signed(a_i) < $signed(b_i)) ? XLEN'(1) : '0;
            default: y_o = '0;
        endcase
    end

    assign zero_o = (y_o == '0);

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import cpu_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [REG_AW-1:0] waddr_i,
    input  logic [XLEN-1:0]   wdata_i,
    input  logic [REG_AW-1:0] raddr_a_i,
    input  logic [REG_AW-1:0] raddr_b_i,
    output logic [XLEN-1:0]   rdata_a_o,
    output logic [XLEN-1:0]   rdata_b_o
);

    localparam int unsigned NREGS = 2 ** REG_AW;

    logic [NREGS-1:0][XLEN-1:0] regs;

    // Register 0 is a constant zero
    assign regs[0] = '0;

    for (genvar g = 1; g < NREGS; g++) begin : g_reg
        logic [XLEN-1:0] r_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                r_q <= '0;
            end else if (we_i && (waddr_i == REG_AW'(g))) begin
                r_q <= wdata_i;
            end
        end
        assign regs[g] = r_q;
    end

    assign rdata_a_o = regs[raddr_a_i];
    assign rdata_b_o = regs[raddr_b_i];

endmodule

// File: rtl/cpu_mem.sv
module cpu_mem #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned IMEM_WORDS = 64,
    parameter int unsigned DMEM_WORDS = 64,
    localparam int unsigned IAW       = $clog2(IMEM_WORDS),
    localparam int unsigned DAW       = $clog2(DMEM_WORDS),
    localparam int unsigned PLAW      = (IAW > DAW) ? IAW : DAW
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pl_en_i,
    input  logic              pl_dmem_i,
    input  logic [PLAW-1:0]   pl_addr_i,
    input  logic [XLEN-1:0]   pl_data_i,
    output logic [XLEN-1:0]   dbg_pc_o,
    output logic              dbg_wr_en_o,
    output logic [REG_AW-1:0] dbg_wr_idx_o,
    output logic [XLEN-1:0]   dbg_wr_data_o
);

    localparam int unsigned DSH = $clog2(XLEN / 8);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t state_d, state_q;

    logic              run;
    logic [ILEN-1:0]   instr;
    ctrl_t             ctrl;
    logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
    logic [XLEN-1:0]   rs_val, rt_val;
    logic [XLEN-1:0]   imm_sx, jmp_sx;
    logic [XLEN-1:0]   alu_b, alu_y;
    logic              alu_zero;
    logic [XLEN-1:0]   dmem_rdata, wb_data;
    logic              wr_en;
    logic              branch_taken;
    logic [XLEN-1:0]   pc_plus4, br_target, jmp_target;
    logic              imem_we, dmem_we;
    logic [DAW-1:0]    dmem_waddr, dmem_raddr;
    logic [XLEN-1:0]   dmem_wdata;

    // The core executes only out of reset and while no preload is active
    assign run = rst_ni && !pl_en_i;

    // Instruction fetch
    assign imem_we = pl_en_i && !pl_dmem_i;

    cpu_mem #(.WIDTH(ILEN), .DEPTH(IMEM_WORDS)) i_imem (
        .clk_i  (clk_i),
        .we_i   (imem_we),
        .waddr_i(pl_addr_i[IAW-1:0]),
        .wdata_i(pl_data_i[ILEN-1:0]),
        .raddr_i(state_q.pc[IAW+1:2]),
        .rdata_o(instr)
    );

    // Decode
    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_idx = instr[15:11];
    assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign jmp_sx = {{(XLEN-26){instr[25]}}, instr[25:0]};

    cpu_decoder i_decoder (
        .instr_i(instr),
        .ctrl_o (ctrl)
    );

    // Register read and write
    assign wr_idx  = ctrl.dst_is_rd ? rd_idx : rt_idx;
    assign wr_en   = run && ctrl.reg_write && (wr_idx != '0);
    assign wb_data = ctrl.mem_read ? dmem_rdata : alu_y;

    cpu_regfile #(.XLEN(XLEN)) i_regfile (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (wr_en),
        .waddr_i  (wr_idx),
        .wdata_i  (wb_data),
        .raddr_a_i(rs_idx),
        .raddr_b_i(rt_idx),
        .rdata_a_o(rs_val),
        .rdata_b_o(rt_val)
    );

    // Execute
    assign alu_b = ctrl.alu_src_imm ? imm_sx : rt_val;

    cpu_alu #(.XLEN(XLEN)) i_alu (
        .a_i   (rs_val),
        .b_i   (alu_b),
        .op_i  (ctrl.alu_op),
        .y_o   (alu_y),
        .zero_o(alu_zero)
    );

    // Data memory, shared write port with the preload path
    assign dmem_raddr = alu_y[DAW+DSH-1:DSH];
    assign dmem_we    = (run && ctrl.mem_write) || (pl_en_i && pl_dmem_i);
    assign dmem_waddr = pl_en_i ? pl_addr_i[DAW-1:0] : dmem_raddr;
    assign dmem_wdata = pl_en_i ? pl_data_i : rt_val;

    cpu_mem #(.WIDTH(XLEN), .DEPTH(DMEM_WORDS)) i_dmem (
        .clk_i  (clk_i),
        .we_i   (dmem_we),
        .waddr_i(dmem_waddr),
        .wdata_i(dmem_wdata),
        .raddr_i(dmem_raddr),
        .rdata_o(dmem_rdata)
    );

    // Next PC
    assign pc_plus4     = state_q.pc + XLEN'(4);
    assign br_target    = pc_plus4 + (imm_sx << 2);
    assign jmp_target   = pc_plus4 + (jmp_sx << 2);
    assign branch_taken = (ctrl.branch_eq && alu_zero) || (ctrl.branch_ne && !alu_zero);

    always_comb begin
        state_d = state_q;
        if (run) begin
            if (ctrl.jump) begin
                state_d.pc = jmp_target;
            end else if (branch_taken) begin
                state_d.pc = br_target;
            end else begin
                state_d.pc = pc_plus4;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Debug view
    assign dbg_pc_o      = state_q.pc;
    assign dbg_wr_en_o   = wr_en;
    assign dbg_wr_idx_o  = wr_idx;
    assign dbg_wr_data_o = wb_data;

    logic unused_bits;
    assign unused_bits = ^{state_q.pc[1:0], state_q.pc[XLEN-1:IAW+2], instr[10:6],
                           alu_y[DSH-1:0], alu_y[XLEN-1:DAW+DSH]};

endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk
    import cpu_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              pl_en_i,
    input logic [ILEN-1:0]   instr,
    input logic [XLEN-1:0]   dbg_pc_o,
    input logic              dbg_wr_en_o,
    input logic [REG_AW-1:0] dbg_wr_idx_o
);

    logic [5:0] op;
    logic       ctl_flow;

    assign op       = instr[31:26];
    assign ctl_flow = (op == OP_BEQ) || (op == OP_BNE) || (op == OP_JMP);

    AST_PC_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_pc_o[1:0] == 2'b00); // R2

    AST_PC_STEPS_BY_FOUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pl_en_i && !ctl_flow) |=> (dbg_pc_o == $past(dbg_pc_o) + XLEN'(4))); // R2

    AST_R0_NEVER_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_wr_en_o |-> (dbg_wr_idx_o != '0)); // R8

    AST_PRELOAD_FREEZES_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pl_en_i |=> $stable(dbg_pc_o)); // R9

    AST_PRELOAD_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pl_en_i |-> !dbg_wr_en_o); // R9

    AST_WRITE_ONLY_KNOWN_WRITERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_wr_en_o |-> ((op == OP_RTYPE) || (op == OP_LD))); // R10

endmodule

bind cpu_core cpu_core_chk #(.XLEN(XLEN)) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pl_en_i     (pl_en_i),
    .instr       (instr),
    .dbg_pc_o    (dbg_pc_o),
    .dbg_wr_en_o (dbg_wr_en_o),
    .dbg_wr_idx_o(dbg_wr_idx_o)
);

// File: tb/test_cpu_core.sv
`timescale 1ns/1ps
module test_cpu_core;

    localparam int unsigned XLEN   = 64;
    localparam realtime     TCLK   = 8.0;
    localparam int unsigned MAXCYC = 200000;

    // Encodings taken from the requirements
    localparam logic [5:0] E_RT  = 6'h00;
    localparam logic [5:0] E_J   = 6'h02;
    localparam logic [5:0] E_BEQ = 6'h04;
    localparam logic [5:0] E_BNE = 6'h05;
    localparam logic [5:0] E_LD  = 6'h23;
    localparam logic [5:0] E_SD  = 6'h2B;
    localparam logic [5:0] F_ADD = 6'h20;
    localparam logic [5:0] F_SUB = 6'h22;
    localparam logic [5:0] F_AND = 6'h24;
    localparam logic [5:0] F_OR  = 6'h25;
    localparam logic [5:0] F_SLT = 6'h2A;

    logic            clk_i = 1'b0;
    logic            rst_ni = 1'b0;
    logic            pl_en_i = 1'b0;
    logic            pl_dmem_i = 1'b0;
    logic [5:0]      pl_addr_i = '0;
    logic [XLEN-1:0] pl_data_i = '0;
    logic [XLEN-1:0] dbg_pc_o;
    logic            dbg_wr_en_o;
    logic [4:0]      dbg_wr_idx_o;
    logic [XLEN-1:0] dbg_wr_data_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(TCLK / 2) clk_i = ~clk_i;

    cpu_core i_cpu_core (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .pl_en_i      (pl_en_i),
        .pl_dmem_i    (pl_dmem_i),
        .pl_addr_i    (pl_addr_i),
        .pl_data_i    (pl_data_i),
        .dbg_pc_o     (dbg_pc_o),
        .dbg_wr_en_o  (dbg_wr_en_o),
        .dbg_wr_idx_o (dbg_wr_idx_o),
        .dbg_wr_data_o(dbg_wr_data_o)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rd, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [5:0] fn);
        return {E_RT, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] off);
        return {E_J, off};
    endfunction

    task automatic chk(input string tag, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic pl_write(input logic to_dmem, input int idx, input logic [XLEN-1:0] data);
        @(negedge clk_i);
        pl_en_i   = 1'b1;
        pl_dmem_i = to_dmem;
        pl_addr_i = 6'(idx);
        pl_data_i = data;
        @(negedge clk_i);
        pl_en_i   = 1'b0;
    endtask

    task automatic hold_reset();
        @(negedge clk_i);
        rst_ni  = 1'b0;
        pl_en_i = 1'b0;
    endtask

    task automatic release_reset();
        @(negedge clk_i);
        rst_ni = 1'b1;
        #1;
    endtask

    // Check the instruction now on view, then move to the next one
    task automatic step(input string tag, input logic [XLEN-1:0] pc, input logic wen,
                        input logic [4:0] idx, input logic [XLEN-1:0] data);
        chk({tag, " pc"}, dbg_pc_o, pc);
        chk({tag, " wr_en"}, XLEN'(dbg_wr_en_o), XLEN'(wen));
        if (wen) begin
            chk({tag, " wr_idx"}, XLEN'(dbg_wr_idx_o), XLEN'(idx));
            chk({tag, " wr_data"}, dbg_wr_data_o, data);
        end
        @(negedge clk_i);
        #1;
    endtask

    task automatic step_pc(input string tag, input logic [XLEN-1:0] pc);
        chk({tag, " pc"}, dbg_pc_o, pc);
        @(negedge clk_i);
        #1;
    endtask

    task automatic t_reset_state();
        hold_reset();
        #1;
        chk("R1 pc during reset", dbg_pc_o, '0);
        chk("R1 no write during reset", XLEN'(dbg_wr_en_o), '0);
    endtask

    task automatic t_arith();
        hold_reset();
        pl_write(1'b1, 0, 64'd100);
        pl_write(1'b1, 1, 64'hFFFF_FFFF_FFFF_FFF9);
        pl_write(1'b1, 63, 64'h1234_5678_9ABC_DEF0);
        pl_write(1'b0, 0,  XLEN'(enc_i(E_LD, 0, 1, 16'd0)));
        pl_write(1'b0, 1,  XLEN'(enc_i(E_LD, 0, 2, 16'd8)));
        pl_write(1'b0, 2,  XLEN'(enc_r(3, 1, 2, F_ADD)));
        pl_write(1'b0, 3,  XLEN'(enc_r(4, 1, 2, F_SUB)));
        pl_write(1'b0, 4,  XLEN'(enc_r(5, 1, 2, F_AND)));
        pl_write(1'b0, 5,  XLEN'(enc_r(6, 1, 2, F_OR)));
        pl_write(1'b0, 6,  XLEN'(enc_r(7, 2, 1, F_SLT)));
        pl_write(1'b0, 7,  XLEN'(enc_r(8, 1, 2, F_SLT)));
        pl_write(1'b0, 8,  XLEN'(enc_r(0, 1, 1, F_ADD)));
        pl_write(1'b0, 9,  XLEN'(enc_i(E_SD, 0, 3, 16'd24)));
        pl_write(1'b0, 10, XLEN'(enc_i(E_LD, 0, 9, 16'd24)));
        pl_write(1'b0, 11, XLEN'(enc_r(10, 0, 0, F_ADD)));
        pl_write(1'b0, 12, XLEN'({6'h3F, 26'h0A5_1234}));
        pl_write(1'b0, 13, XLEN'(enc_r(12, 1, 2, 6'h3F)));
        pl_write(1'b0, 14, XLEN'(enc_i(E_LD, 0, 11, 16'hFFF8)));
        release_reset();
        step("R5 load r1",          64'd0,  1'b1, 5'd1,  64'd100);
        step("R5 load r2",          64'd4,  1'b1, 5'd2,  64'hFFFF_FFFF_FFFF_FFF9);
        step("R3 add",              64'd8,  1'b1, 5'd3,  64'd93);
        step("R3 sub",              64'd12, 1'b1, 5'd4,  64'd107);
        step("R3 and",              64'd16, 1'b1, 5'd5,  64'd96);
        step("R3 or",               64'd20, 1'b1, 5'd6,  64'hFFFF_FFFF_FFFF_FFFD);
        step("R4 slt negative",     64'd24, 1'b1, 5'd7,  64'd1);
        step("R4 slt positive",     64'd28, 1'b1, 5'd8,  64'd0);
        step("R8 write to r0",      64'd32, 1'b0, 5'd0,  64'd0);
        step("R5 store",            64'd36, 1'b0, 5'd0,  64'd0);
        step("R5 load back",        64'd40, 1'b1, 5'd9,  64'd93);
        step("R8 r0 reads zero",    64'd44, 1'b1, 5'd10, 64'd0);
        step("R10 unknown opcode",  64'd48, 1'b0, 5'd0,  64'd0);
        step("R10 unknown func",    64'd52, 1'b0, 5'd0,  64'd0);
        step("R5 negative offset",  64'd56, 1'b1, 5'd11, 64'h1234_5678_9ABC_DEF0);
        chk("R2 pc after sequence", dbg_pc_o, 64'd60);
    endtask

    task automatic t_branch();
        hold_reset();
        pl_write(1'b1, 0, 64'd5);
        pl_write(1'b1, 1, 64'd5);
        pl_write(1'b1, 2, 64'd9);
        pl_write(1'b0, 0,  XLEN'(enc_i(E_LD, 0, 1, 16'd0)));
        pl_write(1'b0, 1,  XLEN'(enc_i(E_LD, 0, 2, 16'd8)));
        pl_write(1'b0, 2,  XLEN'(enc_i(E_LD, 0, 3, 16'd16)));
        pl_write(1'b0, 3,  XLEN'(enc_i(E_BEQ, 1, 2, 16'd2)));
        pl_write(1'b0, 4,  XLEN'(enc_r(20, 1, 1, F_ADD)));
        pl_write(1'b0, 5,  XLEN'(enc_r(20, 1, 1, F_ADD)));
        pl_write(1'b0, 6,  XLEN'(enc_i(E_BNE, 1, 2, 16'd5)));
        pl_write(1'b0, 7,  XLEN'(enc_i(E_BEQ, 1, 3, 16'd5)));
        pl_write(1'b0, 8,  XLEN'(enc_i(E_BNE, 1, 3, 16'd1)));
        pl_write(1'b0, 9,  XLEN'(enc_r(20, 1, 1, F_ADD)));
        pl_write(1'b0, 10, XLEN'(enc_j(26'd3)));
        pl_write(1'b0, 14, XLEN'(enc_j(26'h3FF_FFF3)));
        release_reset();
        step_pc("R2 seq 0", 64'd0);
        step_pc("R2 seq 1", 64'd4);
        step_pc("R2 seq 2", 64'd8);
        step_pc("R6 beq taken source", 64'd12);
        step_pc("R6 beq taken target", 64'd24);
        step_pc("R6 bne not taken", 64'd28);
        step_pc("R6 beq not taken", 64'd32);
        step_pc("R6 bne taken target", 64'd40);
        step_pc("R7 forward jump target", 64'd56);
        step("R7 backward jump target", 64'd8, 1'b1, 5'd3, 64'd9);
    endtask

    task automatic t_preload_hold();
        hold_reset();
        pl_write(1'b1, 0, 64'd11);
        pl_write(1'b0, 0, XLEN'(enc_i(E_LD, 0, 1, 16'd0)));
        pl_write(1'b0, 1, XLEN'(enc_i(E_LD, 0, 2, 16'd40)));
        release_reset();
        step("R9 first load", 64'd0, 1'b1, 5'd1, 64'd11);
        pl_en_i   = 1'b1;
        pl_dmem_i = 1'b1;
        pl_addr_i = 6'd5;
        pl_data_i = 64'h0ABC;
        #1;
        chk("R9 write blocked", XLEN'(dbg_wr_en_o), '0);
        chk("R9 pc held", dbg_pc_o, 64'd4);
        @(negedge clk_i);
        #1;
        chk("R9 pc still held", dbg_pc_o, 64'd4);
        pl_en_i = 1'b0;
        #1;
        step("R9 preloaded data", 64'd4, 1'b1, 5'd2, 64'h0ABC);
        chk("R9 resumes", dbg_pc_o, 64'd8);
    endtask

    task automatic t_reset_clears();
        hold_reset();
        pl_write(1'b0, 0, XLEN'(enc_r(3, 1, 2, F_OR)));
        release_reset();
        step("R1 registers cleared", 64'd0, 1'b1, 5'd3, 64'd0);
        chk("R1 then R2 step", dbg_pc_o, 64'd4);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(TCLK * MAXCYC);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset_state();
        t_arith();
        t_branch();
        t_preload_hold();
        t_reset_clears();
        summary();
        $finish;
    end

endmodule